// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to 64 interrupt sources, keeps an enable bit, a pending bit and a five-bit priority for each one, and offers the most urgent eligible source to a processor core. Software reaches the state through a plain register port. Enable and pending state sit in word-wide set and clear banks. Priorities are held in one byte-wide register per source.

The core sees a request line and the number of the winning source. It accepts the request with an acknowledge pulse and reports the end of a handler with an exit pulse. Accepted sources are pushed onto a small stack of active priorities. A new request is offered only when its priority value is strictly below the priority on top of that stack. A global mask input holds off every request without losing any pending state. Level inputs from the sources raise pending bits. A source that is in service does not raise its pending bit again until its handler exits.

Top module: `pvic_top`

## Requirements
- R1: Source n uses bit n%32 of enable word n/32. Writing a 1 to the word at 0x100+4w sets enable bits, and writing a 1 to the word at 0x180+4w clears them. A read of either address returns the enable word, so IRQ 33 is bit 1 at 0x104.
- R2: Writing a 1 to the word at 0x200+4w sets pending bits, and writing a 1 to the word at 0x280+4w clears them. A read of either address returns the pending word. In all four banks a 0 bit in the written data leaves the corresponding bit unchanged.
- R3: The priority of source n is the byte at 0x400+n, written through the byte enables. Only data bits 7..3 of the byte are kept, and bits 2..0 read back as zero.
- R4: A source that is pending but not enabled never raises irq_req.
- R5: Among sources that are enabled, pending and not active, the one with the lowest priority value is offered on irq_num. When priority values are equal, the lowest IRQ number wins.
- R6: An acknowledge while irq_req is high clears the pending bit of the offered source and makes it active. An active source is never offered again until it exits.
- R7: While a handler is active, irq_req rises only for a source whose priority value is strictly below that handler's priority. An equal value does not preempt.
- R8: While glob_mask is high, irq_req stays low. Pending bits are kept, and the request returns as soon as the mask is released.
- R9: An exit pulse pops the top active entry and restores the threshold of the handler underneath it. With no entry left, any priority may be requested.
- R10: A high src_level bit sets its pending bit at the next clock edge unless that source is active. After the exit of that source, a still-high level sets the pending bit again one edge later.
- R11: When NEST_DEPTH handlers are active, irq_req stays low until an exit.
- R12: After a synchronous reset all enable, pending and priority state is zero, nothing is active and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for priority writes |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_level | input | NUM_SRC | Level inputs from the interrupt sources |
| glob_mask | input | 1 | Blocks all requests while high |
| irq_req | output | 1 | Request to the core |
| irq_num | output | $clog2(NUM_SRC) | Number of the offered source |
| irq_ack | input | 1 | Core accepts the offered source |
| irq_exit | input | 1 | Core finished the current handler |

## Verification
A corrupted active stack shows up at the ports on the very next cycle. It either offers a source of equal priority or suppresses one that should preempt, and after an exit the wrong threshold stays visible until the stack is empty again. A missed automatic pending clear reads back at 0x200 in the cycle after the acknowledge, and a wrong tie-break or comparator appears on irq_num in the same cycle as the register write that sets up the pattern. The random patterns mix dense and sparse enable and pending sets with random priority bytes, so that tie-breaks and partial-bit comparisons occur often.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int PRIO_W = 5;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_PRIO
    } region_e;

    // One entry of the active-handler stack
    typedef struct packed {
        logic [7:0] irq;
        prio_t      prio;
    } nest_ent_t;

    // Address windows: 0x100 set-en, 0x180 clr-en, 0x200 set-pend, 0x280 clr-pend, 0x400.. prio
    function automatic region_e region_of(input logic [11:0] a);
        case (a[11:7])
            5'h02:        return RG_SETEN;
            5'h03:        return RG_CLREN;
            5'h04:        return RG_SETPD;
            5'h05:        return RG_CLRPD;
            5'h08, 5'h09: return RG_PRIO;
            default:      return RG_NONE;
        endcase
    endfunction

    function automatic logic [7:0] prio_byte(input prio_t p);
        return {p, 3'b000};
    endfunction

endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [11:0]             bus_addr,
    input  logic                    bus_wr,
    input  logic [31:0]             bus_wdata,
    input  logic [3:0]              bus_be,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_SRC-1:0]      src_level,
    input  logic [NUM_SRC-1:0]      act_vec,
    input  logic                    take,
    input  logic [7:0]              take_irq,
    output logic [NUM_SRC-1:0]      en_q,
    output logic [NUM_SRC-1:0]      pend_q,
    output prio_t [NUM_SRC-1:0]     prio_q
);
    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
    localparam int PAD       = NUM_WORDS * 32;

    region_e             rg;
    logic [4:0]          widx;
    logic [5:0]          pidx;
    logic [NUM_SRC-1:0]  en_nxt, pend_nxt;
    logic [PAD-1:0]      en_pad, pend_pad;

    assign rg       = region_of(bus_addr);
    assign widx     = bus_addr[6:2];
    assign pidx     = bus_addr[7:2];
    assign en_pad   = PAD'(en_q);
    assign pend_pad = PAD'(pend_q);

    always_comb begin
        en_nxt   = en_q;
        pend_nxt = pend_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // level inputs raise pending only for sources not in service
            if (src_level[i] && !act_vec[i])
                pend_nxt[i] = 1'b1;
            if (bus_wr && int'(widx) == i / 32 && bus_wdata[i % 32]) begin
                if (rg == RG_SETEN) en_nxt[i]   = 1'b1;
                if (rg == RG_CLREN) en_nxt[i]   = 1'b0;
                if (rg == RG_SETPD) pend_nxt[i] = 1'b1;
                if (rg == RG_CLRPD) pend_nxt[i] = 1'b0;
            end
            // acceptance by the core clears pending last
            if (take && int'(take_irq) == i)
                pend_nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_nxt;
            pend_q <= pend_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_wr && rg == RG_PRIO && int'(pidx) == i / 4 && bus_be[i % 4])
                    prio_q[i] <= bus_wdata[8 * (i % 4) + 3 +: PRIO_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rg == RG_SETEN || rg == RG_CLREN) begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (int'(widx) == w) bus_rdata = en_pad[w * 32 +: 32];
        end else if (rg == RG_SETPD || rg == RG_CLRPD) begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (int'(widx) == w) bus_rdata = pend_pad[w * 32 +: 32];
        end else if (rg == RG_PRIO) begin
            for (int i = 0; i < NUM_SRC; i++)
                if (int'(pidx) == i / 4) bus_rdata[8 * (i % 4) +: 8] = prio_byte(prio_q[i]);
        end
    end

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]  cand,
    input  prio_t [NUM_SRC-1:0] prio,
    output logic                win_valid,
    output logic [7:0]          win_irq,
    output prio_t               win_prio
);
    // Ascending scan with strict compare: ties keep the lower IRQ number
    always_comb begin
        win_valid = 1'b0;
        win_irq   = '0;
        win_prio  = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!win_valid || prio[i] < win_prio)) begin
                win_valid = 1'b1;
                win_irq   = 8'(i);
                win_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/pvic_nest.sv
module pvic_nest
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DEPTH   = 4,
    localparam int DW     = $clog2(DEPTH + 1),
    localparam int IRQ_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [7:0]         take_irq,
    input  prio_t              take_prio,
    input  logic               exit_req,
    output logic [5:0]         thresh,
    output logic               full,
    output logic [DW-1:0]      depth,
    output logic [NUM_SRC-1:0] act_vec
);
    nest_ent_t     stk [DEPTH];
    logic [DW-1:0] cnt;

    assign depth = cnt;
    assign full  = (cnt == DW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (exit_req && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (take && !full) begin
            for (int i = 0; i < DEPTH; i++)
                if (DW'(i) == cnt) stk[i] <= '{irq: take_irq, prio: take_prio};
            cnt <= cnt + 1'b1;
        end
    end

    // Top of stack gives the threshold; 32 means idle (any priority passes)
    always_comb begin
        thresh  = 6'd32;
        act_vec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (DW'(i) < cnt) begin
                thresh = {1'b0, stk[i].prio};
                act_vec[stk[i].irq[IRQ_W-1:0]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NEST_DEPTH = 4,
    localparam int IRQ_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_be,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               glob_mask,
    output logic               irq_req,
    output logic [IRQ_W-1:0]   irq_num,
    input  logic               irq_ack,
    input  logic               irq_exit
);
    localparam int DW = $clog2(NEST_DEPTH + 1);

    logic [NUM_SRC-1:0]  en_q, pend_q, act_vec, cand;
    prio_t [NUM_SRC-1:0] prio_q;
    logic                win_valid, full, take;
    logic [7:0]          win_irq;
    prio_t               win_prio;
    logic [5:0]          thresh;
    logic [DW-1:0]       depth;

    assign cand    = pend_q & en_q & ~act_vec;
    assign irq_req = win_valid && !glob_mask && !full && ({1'b0, win_prio} < thresh);
    assign irq_num = win_irq[IRQ_W-1:0];
    // exit takes precedence over an acknowledge in the same cycle
    assign take    = irq_ack && irq_req && !irq_exit;

    pvic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .src_level (src_level),
        .act_vec   (act_vec),
        .take      (take),
        .take_irq  (win_irq),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prio_q    (prio_q)
    );

    pvic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .cand      (cand),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_irq   (win_irq),
        .win_prio  (win_prio)
    );

    pvic_nest #(.NUM_SRC(NUM_SRC), .DEPTH(NEST_DEPTH)) u_nest (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_irq  (win_irq),
        .take_prio (win_prio),
        .exit_req  (irq_exit),
        .thresh    (thresh),
        .full      (full),
        .depth     (depth),
        .act_vec   (act_vec)
    );

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int NUM_SRC = 64,
    parameter int DEPTH   = 4,
    parameter int IRQ_W   = 6,
    parameter int DW      = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               glob_mask,
    input logic               irq_req,
    input logic [IRQ_W-1:0]   irq_num,
    input logic               irq_ack,
    input logic               irq_exit,
    input logic [NUM_SRC-1:0] en_vec,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [NUM_SRC-1:0] act_vec,
    input logic [4:0]         best_prio,
    input logic [5:0]         thresh,
    input logic [DW-1:0]      depth
);
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        glob_mask |-> !irq_req); // R8

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (en_vec[irq_num] && pend_vec[irq_num])); // R4

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ({1'b0, best_prio} < thresh)); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && !irq_exit) |=> (!pend_vec[$past(irq_num)] && act_vec[$past(irq_num)])); // R6

    AST_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !act_vec[irq_num]); // R6

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (depth == DW'(DEPTH)) |-> !irq_req); // R11

    AST_EXIT_POPS: assert property (@(posedge clk) disable iff (rst)
        (irq_exit && depth != '0) |=> (depth == $past(depth) - 1'b1)); // R9

endmodule

bind pvic_top pvic_checker #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (NEST_DEPTH),
    .IRQ_W   (IRQ_W),
    .DW      (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .glob_mask (glob_mask),
    .irq_req   (irq_req),
    .irq_num   (irq_num),
    .irq_ack   (irq_ack),
    .irq_exit  (irq_exit),
    .en_vec    (en_q),
    .pend_vec  (pend_q),
    .act_vec   (act_vec),
    .best_prio (win_prio),
    .thresh    (thresh),
    .depth     (depth)
);

// File: tb/sim_pvic_top.sv
`timescale 1ns/1ps
module sim_pvic_top;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] src_level = '0;
    logic        glob_mask = 1'b0;
    logic        irq_req;
    logic [5:0]  irq_num;
    logic        irq_ack = 1'b0;
    logic        irq_exit = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0]      m_prio [NSRC];
    logic [NSRC-1:0] m_en, m_pend;

    always #4 clk = ~clk;

    pvic_top #(.NUM_SRC(NSRC), .NEST_DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .src_level(src_level), .glob_mask(glob_mask), .irq_req(irq_req),
        .irq_num(irq_num), .irq_ack(irq_ack), .irq_exit(irq_exit)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1;
    endtask

    task automatic do_exit();
        @(negedge clk); irq_exit = 1'b1;
        @(negedge clk); irq_exit = 1'b0;
        #1;
    endtask

    function automatic logic [6:0] expect_win();
        logic found = 1'b0;
        logic [5:0] best = '0;
        logic [4:0] bp = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (m_en[i] && m_pend[i] && (!found || m_prio[i] < bp)) begin
                found = 1'b1; best = 6'(i); bp = m_prio[i];
            end
        end
        return {found, best};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  ew;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R12 reset state
        chk("R12 req after reset", {31'd0, irq_req}, 0);
        rd(12'h100, d); chk("R12 enable word", d, 0);
        rd(12'h200, d); chk("R12 pending word", d, 0);
        rd(12'h400, d); chk("R12 priority word", d, 0);

        // R1 enable banks, IRQ 33 = bit 1 of word 1
        wr(12'h104, 32'h2, 4'hF);
        rd(12'h104, d); chk("R1 set-enable IRQ33", d, 32'h2);
        rd(12'h184, d); chk("R1 clear-enable alias read", d, 32'h2);
        rd(12'h100, d); chk("R1 word 0 untouched", d, 0);
        wr(12'h104, 32'h0, 4'hF);
        rd(12'h104, d); chk("R1 zero write no effect", d, 32'h2);
        wr(12'h184, 32'h2, 4'hF);
        rd(12'h104, d); chk("R1 clear-enable", d, 0);

        // R3 priority bytes, IRQ 33 at byte 0x421
        wr(12'h420, 32'hFFFF_FFFF, 4'b0010);
        rd(12'h420, d); chk("R3 byte lane write", d, 32'h0000_F800);
        wr(12'h420, 32'h0000_0017, 4'b0001);
        rd(12'h420, d); chk("R3 low bits dropped", d, 32'h0000_F810);
        wr(12'h420, 32'h0, 4'hF);

        // prio IRQ5 = 2, IRQ3 = 2
        wr(12'h404, 32'h0000_1000, 4'b0010);
        wr(12'h400, 32'h1000_0000, 4'b1000);

        // R4 / R2
        wr(12'h200, 32'h20, 4'hF);
        rd(12'h200, d); chk("R2 set-pending", d, 32'h20);
        chk("R4 disabled pending no req", {31'd0, irq_req}, 0);
        wr(12'h200, 32'h0, 4'hF);
        rd(12'h200, d); chk("R2 zero write no effect", d, 32'h20);

        // R5 tie then priority
        wr(12'h100, 32'h20, 4'hF);
        chk("R5 req single", {31'd0, irq_req}, 1);
        chk("R5 num single", {26'd0, irq_num}, 5);
        wr(12'h200, 32'h08, 4'hF);
        wr(12'h100, 32'h08, 4'hF);
        chk("R5 tie lowest number", {26'd0, irq_num}, 3);
        wr(12'h400, 32'h1800_0000, 4'b1000);
        chk("R5 lower value wins", {26'd0, irq_num}, 5);
        wr(12'h280, 32'h08, 4'hF);
        rd(12'h200, d); chk("R2 clear-pending", d, 32'h20);

        // R8 mask
        @(negedge clk); glob_mask = 1'b1; #1;
        chk("R8 masked no req", {31'd0, irq_req}, 0);
        rd(12'h200, d); chk("R8 pending kept", d, 32'h20);
        @(negedge clk); glob_mask = 1'b0; #1;
        chk("R8 req after release", {31'd0, irq_req}, 1);

        // R6 ack
        ack();
        rd(12'h200, d); chk("R6 pending auto-cleared", d, 0);
        chk("R6 no req after ack", {31'd0, irq_req}, 0);

        // R7 preemption: IRQ7 prio 2 (equal), IRQ9 prio 1
        wr(12'h404, 32'h1000_0000, 4'b1000);
        wr(12'h200, 32'h80, 4'hF);
        wr(12'h100, 32'h80, 4'hF);
        chk("R7 equal prio no preempt", {31'd0, irq_req}, 0);
        wr(12'h408, 32'h0000_0800, 4'b0010);
        wr(12'h200, 32'h200, 4'hF);
        wr(12'h100, 32'h200, 4'hF);
        chk("R7 higher preempts req", {31'd0, irq_req}, 1);
        chk("R7 higher preempts num", {26'd0, irq_num}, 9);
        ack();
        chk("R7 nested blocks equal", {31'd0, irq_req}, 0);

        // R9 exits restore thresholds
        do_exit();
        chk("R9 threshold back to 2", {31'd0, irq_req}, 0);
        do_exit();
        chk("R9 idle allows req", {31'd0, irq_req}, 1);
        chk("R9 idle num", {26'd0, irq_num}, 7);
        ack();
        do_exit();
        chk("R9 all clear", {31'd0, irq_req}, 0);

        // R10 level input on IRQ40 (word 1 bit 8)
        wr(12'h104, 32'h100, 4'hF);
        @(negedge clk); src_level[40] = 1'b1;
        @(negedge clk); #1;
        rd(12'h204, d); chk("R10 level sets pending", d, 32'h100);
        chk("R10 level num", {26'd0, irq_num}, 40);
        ack();
        repeat (3) @(negedge clk);
        #1;
        rd(12'h204, d); chk("R10 no re-pend while active", d, 0);
        do_exit();
        rd(12'h204, d); chk("R10 not yet re-pended at exit edge", d, 0);
        @(negedge clk); #1;
        rd(12'h204, d); chk("R10 re-pend after exit", d, 32'h100);
        @(negedge clk); src_level[40] = 1'b0;
        wr(12'h284, 32'h100, 4'hF);
        wr(12'h184, 32'hFFFF_FFFF, 4'hF);

        // R11 depth limit: IRQ10..14 prio 20,15,10,5,1
        wr(12'h408, 32'h78A0_0000, 4'b1100);
        wr(12'h40C, 32'h0008_2850, 4'b0111);
        wr(12'h100, 32'h7C00, 4'hF);
        for (int k = 10; k < 14; k++) begin
            wr(12'h200, 32'h1 << k, 4'hF);
            chk("R11 nest step num", {26'd0, irq_num}, 32'(k));
            chk("R11 nest step req", {31'd0, irq_req}, 1);
            ack();
        end
        wr(12'h200, 32'h4000, 4'hF);
        chk("R11 full stack blocks", {31'd0, irq_req}, 0);
        do_exit();
        chk("R11 req after exit", {31'd0, irq_req}, 1);
        chk("R11 num after exit", {26'd0, irq_num}, 14);
        wr(12'h280, 32'h4000, 4'hF);
        repeat (3) do_exit();
        chk("R11 drained", {31'd0, irq_req}, 0);
        wr(12'h180, 32'hFFFF_FFFF, 4'hF);

        // R5 / R3 random patterns
        for (int it = 0; it < 150; it++) begin
            for (int w = 0; w < 16; w++) begin
                logic [31:0] pv = $urandom();
                if (it % 3 == 0) pv = pv & 32'h1818_1818;
                wr(12'h400 + 12'(4 * w), pv, 4'hF);
                for (int b = 0; b < 4; b++) m_prio[4 * w + b] = pv[8 * b + 3 +: 5];
                if (w == it % 16) begin
                    rd(12'h400 + 12'(4 * w), d);
                    chk("R3 random readback", d, pv & 32'hF8F8_F8F8);
                end
            end
            m_en   = {$urandom() | $urandom(), $urandom() & $urandom()};
            m_pend = {$urandom() & $urandom(), $urandom() & $urandom() & $urandom()};
            wr(12'h280, 32'hFFFF_FFFF, 4'hF);
            wr(12'h284, 32'hFFFF_FFFF, 4'hF);
            wr(12'h180, 32'hFFFF_FFFF, 4'hF);
            wr(12'h184, 32'hFFFF_FFFF, 4'hF);
            wr(12'h100, m_en[31:0], 4'hF);
            wr(12'h104, m_en[63:32], 4'hF);
            wr(12'h200, m_pend[31:0], 4'hF);
            wr(12'h204, m_pend[63:32], 4'hF);
            ew = expect_win();
            chk("R5 random req", {31'd0, irq_req}, {31'd0, ew[6]});
            if (ew[6]) chk("R5 random winner", {26'd0, irq_num}, {26'd0, ew[5:0]});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule